// File: doc/BRIEF.md
# I2C Receive Interrupt and Wait Controller

This block works next to an I2C byte shift engine. It decides when a byte-transfer interrupt goes to software, and it holds the clock line low until software answers. The engine gives it two single-cycle strobes: one for the falling edge of the 8th SCL clock and one for the falling edge of the 9th (acknowledge) SCL clock. The block also receives the current mode flags and the write strobes for the data register and for the acknowledge-bit field.

An interrupt is always raised at the 9th clock. While a data byte is being received with the acknowledge clock on, software can also ask for an earlier interrupt at the 8th clock. This lets it choose the acknowledge value before the acknowledge clock runs. A hidden wait flag records which interrupt point is next, and so which register write resumes the transfer:

- A data-register write arms the wait flag to 1.
- An acknowledge-bit write clears the wait flag to 0.

Reading the early-interrupt control bit returns this wait flag.

Top module: `i2c_rx_irq_wait`

## Requirements
- R1: After a synchronous active-low reset, `pend_n` is 1, `scl_hold` is 0, `irq_pulse` is 0 and `wait_rd` is 0.
- R2: A `clk9_fall` strobe always makes `irq_pulse` 1 for exactly the next cycle and drives `pend_n` to 0. This holds whatever the mode and enable inputs are.
- R3: A `clk8_fall` strobe raises an interrupt only when all of the following hold: `early_en`=1, `ack_clk_en`=1, `xmit`=0, `addr_phase`=0 and `wait_rd`=1. The interrupt then appears one cycle later.
- R4: While `xmit`=1 (transmit) or `addr_phase`=1 (slave address byte), no 8th-clock interrupt occurs and `wait_rd` reads 0.
- R5: While `ack_clk_en`=0, the early interrupt acts as disabled: no 8th-clock interrupt occurs and `wait_rd` reads 0.
- R6: While the early interrupt is effective, a `wr_data` strobe sets `wait_rd` to 1 and a `wr_ackbit` strobe clears it to 0, one cycle after the strobe.
- R7: `scl_hold` is 1 exactly while `pend_n` is 0. A pending request stays pending until its matching restart write arrives.
- R8: After an 8th-clock interrupt, `wr_ackbit` releases the request: one cycle later `pend_n` is 1 and `scl_hold` is 0. A `wr_data` strobe leaves the request pending.
- R9: After a 9th-clock interrupt, `wr_data` releases the request: one cycle later `pend_n` is 1 and `scl_hold` is 0. A `wr_ackbit` strobe leaves the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| early_en | input | 1 | Stored early-interrupt enable (1 = interrupt at 8th clock on received data) |
| ack_clk_en | input | 1 | 1 = acknowledge clock is generated |
| xmit | input | 1 | 1 = transmit, 0 = receive |
| addr_phase | input | 1 | 1 = slave address byte in progress |
| clk8_fall | input | 1 | Single-cycle strobe at the falling edge of the 8th SCL clock |
| clk9_fall | input | 1 | Single-cycle strobe at the falling edge of the 9th SCL clock |
| wr_data | input | 1 | Single-cycle strobe: data register written |
| wr_ackbit | input | 1 | Single-cycle strobe: acknowledge-bit field written |
| pend_n | output | 1 | Active-low request pending flag |
| irq_pulse | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |
| wait_rd | output | 1 | Readback of the early-interrupt bit (internal wait flag) |

## Verification
A wait flag stuck in the wrong state shows up at the next interrupt point. Two symptoms are possible: an 8th-clock strobe that yields no interrupt, or a restart write that leaves `pend_n` low and the clock held. Both are visible one cycle after the strobe. A wrongly recorded interrupt source appears one cycle after the first restart write, as a release that does not happen or an early release. The directed scenarios pair each interrupt point with both the matching and the non-matching write so that either mistake shows at once.

// File: rtl/i2cw_pkg.sv
// Package: shared types for the I2C receive interrupt/wait controller.
// Assumes nothing beyond IEEE 1800-2017.
package i2cw_pkg;
    // Which interrupt point raised the current pending request
    typedef enum logic {
        SRC_ACK_CLK = 1'b0,
        SRC_EARLY   = 1'b1
    } irq_src_e;
endpackage

// File: rtl/i2cw_gate.sv
// Module: i2cw_gate
// Decides whether the early (8th-clock) interrupt is effective.
// Assumes mode flags are stable levels from the shift engine / control regs.
module i2cw_gate (
    input  logic early_en,
    input  logic ack_clk_en,
    input  logic xmit,
    input  logic addr_phase,
    output logic early_ok
);
    // Early point only for received data bytes with an ACK clock
    always_comb begin
        early_ok = early_en && ack_clk_en && !xmit && !addr_phase;
    end
endmodule

// File: rtl/i2cw_wait_flag.sv
// Module: i2cw_wait_flag
// Holds the hidden wait flag: armed by a data write, cleared by an ACK-bit
// write, forced to 0 whenever the early interrupt is not effective.
// Assumes write strobes are single-cycle and synchronous to clk.
module i2cw_wait_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic early_ok,
    input  logic wr_data,
    input  logic wr_ackbit,
    output logic wait_q
);
    // Update wait flag from the register write strobes
    always_ff @(posedge clk) begin
        if (!rst_n)          wait_q <= 1'b0;
        else if (!early_ok)  wait_q <= 1'b0;
        else if (wr_data)    wait_q <= 1'b1;
        else if (wr_ackbit)  wait_q <= 1'b0;
    end
endmodule

// File: rtl/i2cw_pend.sv
// Module: i2cw_pend
// Tracks one pending interrupt request and its source, emits the interrupt
// pulse and the SCL hold, and releases on the matching restart write.
// Assumes a new interrupt point never coincides with a restart write.
module i2cw_pend
    import i2cw_pkg::*;
#(
    parameter bit HOLD_ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_early,
    input  logic fire_ack,
    input  logic wr_data,
    input  logic wr_ackbit,
    output logic pend_n,
    output logic irq_pulse,
    output logic scl_hold
);
    logic     pending_q;
    irq_src_e src_q;
    logic     release_hit;

    // Restart write that matches the recorded interrupt point
    always_comb begin
        release_hit = (src_q == SRC_EARLY) ? wr_ackbit : wr_data;
    end

    // Pending state, source capture and one-cycle interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            src_q     <= SRC_ACK_CLK;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= fire_early || fire_ack;
            if (fire_ack) begin
                pending_q <= 1'b1;
                src_q     <= SRC_ACK_CLK;
            end else if (fire_early) begin
                pending_q <= 1'b1;
                src_q     <= SRC_EARLY;
            end else if (pending_q && release_hit) begin
                pending_q <= 1'b0;
            end
        end
    end

    assign pend_n = !pending_q;

    // Variant: clock stretching on a pending request, or never
    generate
        if (HOLD_ENABLE) begin : g_hold
            assign scl_hold = pending_q;
        end else begin : g_nohold
            assign scl_hold = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/i2c_rx_irq_wait.sv
// Module: i2c_rx_irq_wait (top)
// Chooses the byte interrupt point (8th or 9th SCL falling edge), keeps the
// hidden wait flag, and holds SCL while a request is pending.
// Assumes clk8_fall/clk9_fall are single-cycle strobes from the shift engine.
module i2c_rx_irq_wait #(
    parameter bit HOLD_ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic early_en,
    input  logic ack_clk_en,
    input  logic xmit,
    input  logic addr_phase,
    input  logic clk8_fall,
    input  logic clk9_fall,
    input  logic wr_data,
    input  logic wr_ackbit,
    output logic pend_n,
    output logic irq_pulse,
    output logic scl_hold,
    output logic wait_rd
);
    logic early_ok;
    logic wait_q;
    logic fire_early;
    logic fire_ack;

    i2cw_gate u_gate (
        .early_en   (early_en),
        .ack_clk_en (ack_clk_en),
        .xmit       (xmit),
        .addr_phase (addr_phase),
        .early_ok   (early_ok)
    );

    i2cw_wait_flag u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .early_ok  (early_ok),
        .wr_data   (wr_data),
        .wr_ackbit (wr_ackbit),
        .wait_q    (wait_q)
    );

    // Interrupt points: 8th clock only when armed, 9th clock always
    always_comb begin
        fire_early = clk8_fall && early_ok && wait_q;
        fire_ack   = clk9_fall;
    end

    i2cw_pend #(.HOLD_ENABLE(HOLD_ENABLE)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_early (fire_early),
        .fire_ack   (fire_ack),
        .wr_data    (wr_data),
        .wr_ackbit  (wr_ackbit),
        .pend_n     (pend_n),
        .irq_pulse  (irq_pulse),
        .scl_hold   (scl_hold)
    );

    assign wait_rd = wait_q;
endmodule

// File: rtl/i2c_rx_irq_wait_chk.sv
// Module: i2c_rx_irq_wait_chk
// Port-level checker for i2c_rx_irq_wait, attached with bind below.
// Assumes the default HOLD_ENABLE variant.
module i2c_rx_irq_wait_chk (
    input logic clk,
    input logic rst_n,
    input logic early_en,
    input logic ack_clk_en,
    input logic xmit,
    input logic addr_phase,
    input logic clk8_fall,
    input logic clk9_fall,
    input logic wr_data,
    input logic wr_ackbit,
    input logic pend_n,
    input logic irq_pulse,
    input logic scl_hold,
    input logic wait_rd
);
    AST_NINTH_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        clk9_fall |=> (irq_pulse && !pend_n)); // R2

    AST_EARLY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk8_fall && !clk9_fall && !(early_en && ack_clk_en && !xmit && !addr_phase))
        |=> !irq_pulse); // R3

    AST_TX_WAIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit || addr_phase) |=> !wait_rd); // R4

    AST_NOACK_WAIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_clk_en |=> !wait_rd); // R5

    AST_DATA_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && early_en && ack_clk_en && !xmit && !addr_phase) |=> wait_rd); // R6

    AST_HOLD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold == !pend_n); // R7

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_n && !wr_data && !wr_ackbit) |=> !pend_n); // R7
endmodule

bind i2c_rx_irq_wait i2c_rx_irq_wait_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .early_en   (early_en),
    .ack_clk_en (ack_clk_en),
    .xmit       (xmit),
    .addr_phase (addr_phase),
    .clk8_fall  (clk8_fall),
    .clk9_fall  (clk9_fall),
    .wr_data    (wr_data),
    .wr_ackbit  (wr_ackbit),
    .pend_n     (pend_n),
    .irq_pulse  (irq_pulse),
    .scl_hold   (scl_hold),
    .wait_rd    (wait_rd)
);

// File: tb/i2c_rx_irq_wait_test.sv
// Bench: directed scenarios for i2c_rx_irq_wait, one task each.
module i2c_rx_irq_wait_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic early_en = 1'b0, ack_clk_en = 1'b1, xmit = 1'b0, addr_phase = 1'b0;
    logic clk8_fall = 1'b0, clk9_fall = 1'b0, wr_data = 1'b0, wr_ackbit = 1'b0;
    logic pend_n, irq_pulse, scl_hold, wait_rd;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    i2c_rx_irq_wait uut (
        .clk(clk), .rst_n(rst_n), .early_en(early_en), .ack_clk_en(ack_clk_en),
        .xmit(xmit), .addr_phase(addr_phase), .clk8_fall(clk8_fall),
        .clk9_fall(clk9_fall), .wr_data(wr_data), .wr_ackbit(wr_ackbit),
        .pend_n(pend_n), .irq_pulse(irq_pulse), .scl_hold(scl_hold),
        .wait_rd(wait_rd)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Check all four outputs at once
    task automatic chk_all(input string req, input logic e_irq, input logic e_pn, input logic e_wait);
        chk(req, "irq_pulse", irq_pulse, e_irq);
        chk(req, "pend_n", pend_n, e_pn);
        chk(req, "scl_hold", scl_hold, !e_pn);
        chk(req, "wait_rd", wait_rd, e_wait);
    endtask

    // Strobe codes: 0=clk8_fall 1=clk9_fall 2=wr_data 3=wr_ackbit
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: clk8_fall = 1'b1;
            1: clk9_fall = 1'b1;
            2: wr_data   = 1'b1;
            default: wr_ackbit = 1'b1;
        endcase
        @(negedge clk);
        clk8_fall = 1'b0; clk9_fall = 1'b0; wr_data = 1'b0; wr_ackbit = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R1", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Early disabled: only 9th-clock interrupts; data write resumes
    task automatic t_ninth_only;
        early_en = 1'b0; ack_clk_en = 1'b1; xmit = 1'b0; addr_phase = 1'b0;
        strobe(0); chk_all("R3", 1'b0, 1'b1, 1'b0);
        strobe(1); chk_all("R2", 1'b1, 1'b0, 1'b0);
        @(negedge clk); chk_all("R7", 1'b0, 1'b0, 1'b0);
        strobe(3); chk_all("R9", 1'b0, 1'b0, 1'b0);
        strobe(2); chk_all("R9", 1'b0, 1'b1, 1'b0);
    endtask

    // Early enabled on received data: full wait flag sequence
    task automatic t_early_seq;
        early_en = 1'b1; ack_clk_en = 1'b1; xmit = 1'b0; addr_phase = 1'b0;
        strobe(2); chk_all("R6", 1'b0, 1'b1, 1'b1);
        strobe(0); chk_all("R3", 1'b1, 1'b0, 1'b1);
        strobe(2); chk_all("R8", 1'b0, 1'b0, 1'b1);
        strobe(3); chk_all("R8", 1'b0, 1'b1, 1'b0);
        strobe(1); chk_all("R2", 1'b1, 1'b0, 1'b0);
        strobe(3); chk_all("R9", 1'b0, 1'b0, 1'b0);
        strobe(2); chk_all("R9", 1'b0, 1'b1, 1'b1);
        strobe(3); chk_all("R6", 1'b0, 1'b1, 1'b0);
        strobe(0); chk_all("R3", 1'b0, 1'b1, 1'b0);
    endtask

    // Transmit or address phase: wait stays 0, no early interrupt
    task automatic t_no_early(input logic tx, input logic ad, input logic ackc, input string req);
        early_en = 1'b1; ack_clk_en = ackc; xmit = tx; addr_phase = ad;
        strobe(2); chk_all(req, 1'b0, 1'b1, 1'b0);
        strobe(0); chk_all(req, 1'b0, 1'b1, 1'b0);
        strobe(1); chk_all("R2", 1'b1, 1'b0, 1'b0);
        strobe(2); chk_all("R9", 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_ninth_only();
        t_early_seq();
        t_no_early(1'b1, 1'b0, 1'b1, "R4");
        t_no_early(1'b0, 1'b1, 1'b1, "R4");
        t_no_early(1'b0, 1'b0, 1'b0, "R5");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule